// File: doc/BRIEF.md
# Masked Base Address Window Decoder

This block sorts each bus access into one of four memory windows, or into none. Every window holds a 16-bit base, which is compared with address bits 31..16, and an 8-bit size field. Each set bit of the size field frees one of address bits 16..23 from the comparison. A window therefore covers 64 KiB times a power of two, and it can sit only on a multiple of its own span. Address bits 31..24 always take part in the comparison.

Each window has its own enable. Two pairing controls fuse windows a+b and c+d into double-width windows. In a fused pair the first window's base, size and enable decide the match, and the result appears on the first window's select. The second window's registers and enable then have no effect, and its select stays low. When several windows match, the lowest-lettered one wins. The decode is purely combinational and is gated by an access-valid strobe. A miss flag marks a valid access that hit nothing.

Top module: `win_decode_top`

## Requirements
- R1: A window with size field 0 is selected exactly when address bits 31..16 equal its base. Address bits 15..0 never affect the decode. Window i's base sits at winBase[16i+15:16i] and its size at winSize[8i+7:8i], with i=0 for window a up to i=3 for window d.
- R2: Size bit k (winSize[8i+k], k=0..7) removes address bit 16+k and base bit k from the comparison for window i. A window with size bits 0 and 1 set and base 0x2000 matches address bits 31..16 from 0x2000 to 0x2003. The masked base bits are ignored.
- R3: Address bits 31..24 are never masked. A difference in any of them prevents a match, even when all size bits are set.
- R4: A window whose enable bit winEn[i] is 0 is never selected.
- R5: At most one winSel bit is high. When several enabled windows match, the lowest index (a before b before c before d) is selected.
- R6: When pairMerge[0] is 1, windows a+b act as one window. That window is decoded from window a's base, size and enable, and the hit drives winSel[0]. winSel[1] stays 0, and window b's base, size and enable are ignored.
- R7: When pairMerge[1] is 1, windows c+d act as one window. That window is decoded from window c's base, size and enable, and the hit drives winSel[2]. winSel[3] stays 0, and window d's registers and enable are ignored.
- R8: When accValid is 0, winSel is all zero and winMiss is 0, whatever the address.
- R9: When accValid is 1, winMiss is 1 exactly when no winSel bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busAddr | input | 32 | Address of the current bus access |
| accValid | input | 1 | High while the address is a valid access |
| winBase | input | 64 | Four packed 16-bit bases, window a in the low bits |
| winSize | input | 32 | Four packed 8-bit size masks, window a in the low bits |
| winEn | input | 4 | Per-window enable, bit 0 = window a |
| pairMerge | input | 2 | Bit 0 fuses a+b, bit 1 fuses c+d |
| winSel | output | 4 | One-hot window select, bit 0 = window a |
| winMiss | output | 1 | Valid access matched no window |

## Verification
Addresses are chosen at the edges of each window's span: the first and last address inside a masked window, the first address outside it, and addresses that differ from a base only in bit 16 or only in bits 24 and 31. These separate a correct mask from one that is shifted by a bit or wrongly extended into the top byte. Overlapping windows with the same base, switched on and off through their enables, show priority and enable gating as separate effects. In fused mode, addresses that only the second window's own registers would accept, and enables set only on the second window, show that its registers have no effect. A base with set bits under its size mask checks that masked base bits are truly ignored.

// File: rtl/win_decode_pkg.sv
package win_decode_pkg;
  localparam int WIN_CNT  = 4;
  localparam int PAIR_CNT = WIN_CNT / 2;

  // Strobes from control to datapath: which comparators may report a hit.
  typedef struct packed {
    logic [WIN_CNT-1:0] cmpEn;
  } winStrb_t;
endpackage

// File: rtl/win_decode_dp.sv
module win_decode_dp
  import win_decode_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 16,
  parameter int MASK_W = 8
) (
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [WIN_CNT*BASE_W-1:0] winBase,
  input  logic [WIN_CNT*MASK_W-1:0] winSize,
  input  winStrb_t                  strb,
  output logic [WIN_CNT-1:0]        rawHit
);
  localparam int FIXED_W = BASE_W - MASK_W;

  logic [BASE_W-1:0] addrUpper;
  assign addrUpper = busAddr[ADDR_W-1 -: BASE_W];

  for (genvar gi = 0; gi < WIN_CNT; gi++) begin : g_cmp
    logic [BASE_W-1:0] baseI;
    logic [BASE_W-1:0] careMask;
    logic [BASE_W-1:0] diffBits;

    assign baseI    = winBase[gi*BASE_W +: BASE_W];
    // Upper bits are never masked; low bits are freed by set size bits.
    assign careMask = ~{{FIXED_W{1'b0}}, winSize[gi*MASK_W +: MASK_W]};
    assign diffBits = (addrUpper ^ baseI) & careMask;
    assign rawHit[gi] = strb.cmpEn[gi] && (diffBits == '0);
  end
endmodule

// File: rtl/win_decode_ctrl.sv
module win_decode_ctrl
  import win_decode_pkg::*;
(
  input  logic                accValid,
  input  logic [WIN_CNT-1:0]  winEn,
  input  logic [PAIR_CNT-1:0] pairMerge,
  input  logic [WIN_CNT-1:0]  rawHit,
  output winStrb_t            strb,
  output logic [WIN_CNT-1:0]  winSel,
  output logic                winMiss
);
  // Second window of a fused pair is switched off; the first one stands in.
  for (genvar gw = 0; gw < WIN_CNT; gw++) begin : g_en
    if ((gw % 2) == 1) begin : g_second
      assign strb.cmpEn[gw] = winEn[gw] && !pairMerge[gw/2];
    end else begin : g_first
      assign strb.cmpEn[gw] = winEn[gw];
    end
  end

  logic [WIN_CNT-1:0] qualHit;
  assign qualHit = accValid ? rawHit : '0;

  always_comb begin
    logic taken;
    taken  = 1'b0;
    winSel = '0;
    for (int i = 0; i < WIN_CNT; i++) begin
      if (qualHit[i] && !taken) begin
        winSel[i] = 1'b1;
        taken     = 1'b1;
      end
    end
    winMiss = accValid && !taken;
  end
endmodule

// File: rtl/win_decode_top.sv
module win_decode_top
  import win_decode_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 16,
  parameter int MASK_W = 8
) (
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic                      accValid,
  input  logic [WIN_CNT*BASE_W-1:0] winBase,
  input  logic [WIN_CNT*MASK_W-1:0] winSize,
  input  logic [WIN_CNT-1:0]        winEn,
  input  logic [PAIR_CNT-1:0]       pairMerge,
  output logic [WIN_CNT-1:0]        winSel,
  output logic                      winMiss
);
  winStrb_t           strb;
  logic [WIN_CNT-1:0] rawHit;

  win_decode_dp #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .MASK_W(MASK_W)) u_dp (
    .busAddr (busAddr),
    .winBase (winBase),
    .winSize (winSize),
    .strb    (strb),
    .rawHit  (rawHit)
  );

  win_decode_ctrl u_ctrl (
    .accValid  (accValid),
    .winEn     (winEn),
    .pairMerge (pairMerge),
    .rawHit    (rawHit),
    .strb      (strb),
    .winSel    (winSel),
    .winMiss   (winMiss)
  );
endmodule

// File: rtl/win_decode_chk.sv
module win_decode_chk
  import win_decode_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 16,
  parameter int MASK_W = 8
) (
  input logic [ADDR_W-1:0]         busAddr,
  input logic                      accValid,
  input logic [WIN_CNT*BASE_W-1:0] winBase,
  input logic [WIN_CNT*MASK_W-1:0] winSize,
  input logic [WIN_CNT-1:0]        winEn,
  input logic [PAIR_CNT-1:0]       pairMerge,
  input logic [WIN_CNT-1:0]        winSel,
  input logic                      winMiss
);
  localparam int TOP_W = ADDR_W - 24;

  always_comb begin
    if (!$isunknown({accValid, winSel, winMiss, winEn, pairMerge})) begin
      p_onehot_sel_r5: assert ($onehot0(winSel))
        else $error("winSel not one-hot");
      if (!accValid) begin
        p_idle_quiet_r8: assert (winSel == '0 && !winMiss)
          else $error("output active without accValid");
      end else begin
        p_miss_exact_r9: assert (winMiss == (winSel == '0))
          else $error("winMiss inconsistent with winSel");
      end
      p_disabled_silent_r4: assert ((winSel & ~winEn) == '0)
        else $error("disabled window selected");
      if (pairMerge[0]) begin
        p_merge_ab_r6: assert (!winSel[1])
          else $error("window b selected while fused");
      end
      if (pairMerge[1]) begin
        p_merge_cd_r7: assert (!winSel[3])
          else $error("window d selected while fused");
      end
      for (int i = 0; i < WIN_CNT; i++) begin
        if (winSel[i]) begin
          p_top_byte_r3: assert (busAddr[ADDR_W-1 -: TOP_W] ==
                                 winBase[i*BASE_W + BASE_W - 1 -: TOP_W])
            else $error("top address byte differs from selected base");
        end
      end
    end
  end
endmodule

bind win_decode_top win_decode_chk #(
  .ADDR_W(ADDR_W), .BASE_W(BASE_W), .MASK_W(MASK_W)
) u_chk (
  .busAddr   (busAddr),
  .accValid  (accValid),
  .winBase   (winBase),
  .winSize   (winSize),
  .winEn     (winEn),
  .pairMerge (pairMerge),
  .winSel    (winSel),
  .winMiss   (winMiss)
);

// File: tb/tb_win_decode_top.sv
module tb_win_decode_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [31:0] busAddr;
  logic        accValid;
  logic [63:0] winBase;
  logic [31:0] winSize;
  logic [3:0]  winEn;
  logic [1:0]  pairMerge;
  logic [3:0]  winSel;
  logic        winMiss;

  int checks = 0;
  int fails  = 0;

  win_decode_top dut (
    .busAddr(busAddr), .accValid(accValid), .winBase(winBase),
    .winSize(winSize), .winEn(winEn), .pairMerge(pairMerge),
    .winSel(winSel), .winMiss(winMiss)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        valid;
    logic [3:0]  en;
    logic [1:0]  merge;
    logic [3:0]  expSel;
    logic        expMiss;
    logic [7:0]  req;
  } vec_t;

  // Windows: a=0x1234/0x00, b=0x2000/0x03, c=0x1234/0x00, d=0x40F0/0xFF
  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1234_5678, 1'b1, 4'hF, 2'b00, 4'b0001, 1'b0, 8'd5},  // R5 a beats c
    '{32'h1234_0000, 1'b1, 4'hE, 2'b00, 4'b0100, 1'b0, 8'd4},  // R4 a off -> c
    '{32'h1235_0000, 1'b1, 4'hF, 2'b00, 4'b0000, 1'b1, 8'd1},  // R1 bit16 differs
    '{32'h1234_FFFF, 1'b1, 4'hF, 2'b00, 4'b0001, 1'b0, 8'd1},  // R1 low bits ignored
    '{32'h2003_FFFF, 1'b1, 4'hF, 2'b00, 4'b0010, 1'b0, 8'd2},  // R2 top of b
    '{32'h2004_0000, 1'b1, 4'hF, 2'b00, 4'b0000, 1'b1, 8'd2},  // R2 past b
    '{32'h4077_0000, 1'b1, 4'hF, 2'b00, 4'b1000, 1'b0, 8'd2},  // R2 d full mask
    '{32'h4177_0000, 1'b1, 4'hF, 2'b00, 4'b0000, 1'b1, 8'd3},  // R3 bit24
    '{32'hC0F0_0000, 1'b1, 4'hF, 2'b00, 4'b0000, 1'b1, 8'd3},  // R3 bit31
    '{32'h1234_0000, 1'b0, 4'hF, 2'b00, 4'b0000, 1'b0, 8'd8},  // R8 idle
    '{32'h2001_0000, 1'b1, 4'hF, 2'b01, 4'b0000, 1'b1, 8'd6},  // R6 b regs ignored
    '{32'h1234_0000, 1'b1, 4'hD, 2'b01, 4'b0001, 1'b0, 8'd6},  // R6 a regs rule
    '{32'h4000_0000, 1'b1, 4'hF, 2'b10, 4'b0000, 1'b1, 8'd7},  // R7 d regs ignored
    '{32'h1234_0000, 1'b1, 4'h6, 2'b10, 4'b0100, 1'b0, 8'd7}   // R7 c drives sel
  };

  task automatic check(input string reqName, input logic [3:0] expSel,
                       input logic expMiss);
    checks++;
    if (winSel !== expSel || winMiss !== expMiss) begin
      fails++;
      $display("FAIL %s: winSel=%b winMiss=%b expected winSel=%b winMiss=%b",
               reqName, winSel, winMiss, expSel, expMiss);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic v,
                       input logic [3:0] e, input logic [1:0] m);
    @(negedge clk);
    busAddr = a; accValid = v; winEn = e; pairMerge = m;
    #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    busAddr = '0; accValid = 1'b0; winEn = '0; pairMerge = '0;
    winBase = {16'h40F0, 16'h1234, 16'h2000, 16'h1234};
    winSize = {8'hFF, 8'h00, 8'h03, 8'h00};
    repeat (2) @(posedge clk);
    #1;
    check("R8 initial idle", 4'b0000, 1'b0);

    for (int k = 0; k < NVEC; k++) begin
      apply(VECS[k].addr, VECS[k].valid, VECS[k].en, VECS[k].merge);
      check($sformatf("R%0d vec%0d", VECS[k].req, k), VECS[k].expSel, VECS[k].expMiss);
    end

    // R2: masked base bits are ignored (a base 0x1237 with size 0x03)
    @(negedge clk);
    winBase[15:0] = 16'h1237; winSize[7:0] = 8'h03;
    apply(32'h1234_0000, 1'b1, 4'h1, 2'b00);
    check("R2 masked base bits", 4'b0001, 1'b0);
    apply(32'h1238_0000, 1'b1, 4'h1, 2'b00);
    check("R2 next block miss", 4'b0000, 1'b1);

    // R9: all windows disabled while valid -> miss
    apply(32'h1234_0000, 1'b1, 4'h0, 2'b00);
    check("R9 all disabled", 4'b0000, 1'b1);

    // R8: idle with a hitting address and both pairs fused
    apply(32'h4000_0000, 1'b0, 4'hF, 2'b11);
    check("R8 idle fused", 4'b0000, 1'b0);

    // R7: d enable alone does not open the fused cd window
    winBase[47:32] = 16'h4000;
    apply(32'h4000_0000, 1'b1, 4'h8, 2'b10);
    check("R7 d enable ignored", 4'b0000, 1'b1);
    apply(32'h4000_0000, 1'b1, 4'h4, 2'b10);
    check("R7 c enable opens pair", 4'b0100, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule